// File: doc/BRIEF.md
# Wait/Signal Synchronization Buffer

This block sits in one node of a ring of cores that run the iterations of a parallel loop in round-robin order. Each iteration holds sequential segments that must run in iteration order across the cores. Before a core enters a segment it issues a wait. The buffer answers that wait only when signal messages for the same segment have arrived from every other core on the ring, that is, from the cores running the earlier iterations. When the core leaves the segment it issues a signal. The buffer turns that signal into a message for the ring, tagged with this node's identity and the segment number.

Incoming messages are stored as one pending bit per (segment, source core) pair. A bit set before the matching wait is kept until a grant consumes it. A second message for a pair that is already pending raises an error pulse. A segment-active output tells the memory path to send accesses to the ring-side cache from the grant until the local signal. For a context switch the whole pending state can be unloaded through a save port, which also flushes it, and loaded again through a restore port.

Top module: `sync_sigbuf`

## Requirements
- R1: A wait for segment s is not granted while any pending bit for segment s from a core other than this node is clear.
- R2: When wait_req is high at a clock edge, no save or restore is sampled at that edge, and all CORES-1 foreign bits for wait_seg are set, wait_gnt goes high after that edge for exactly one cycle. The same edge clears those bits.
- R3: Ring messages that arrive before the matching wait are held, so a later wait on a fully signalled segment is granted one cycle after it is presented.
- R4: A sig_req sampled at an edge makes ring_out_vld high for one cycle after that edge, with ring_out_src equal to NODE_ID and ring_out_seg equal to sig_seg.
- R5: seg_active rises at the same edge as wait_gnt and falls at the edge that samples sig_req.
- R6: A ring message for a (segment, source) pair that is already pending, and is not being consumed at that edge, makes dup_err high for one cycle after the edge. The bit stays set.
- R7: A ring message whose source equals NODE_ID has no effect, and restore never sets this node's own bits.
- R8: A save_req sampled at an edge (without restore_req) makes save_vld high for one cycle after the edge. save_data then carries the pending state, including any message sampled at that edge, with bit index seg*CORES+src. The pending state becomes all zero.
- R9: A restore_req sampled at an edge loads restore_data (same layout, own bits masked), plus any message sampled at that edge. Restore takes priority over a simultaneous save, which is then dropped. No wait is granted at an edge that samples save_req or restore_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Core wait request, held until granted |
| wait_seg | input | SEG_W | Segment the wait is for |
| wait_gnt | output | 1 | One-cycle wait grant |
| seg_active | output | 1 | Segment in progress: route memory accesses to the ring cache |
| sig_req | input | 1 | Core signal, one cycle per segment end |
| sig_seg | input | SEG_W | Segment being signalled |
| ring_in_vld | input | 1 | Incoming signal message valid |
| ring_in_src | input | CID_W | Source core of the incoming message |
| ring_in_seg | input | SEG_W | Segment of the incoming message |
| ring_out_vld | output | 1 | Outgoing signal message valid |
| ring_out_src | output | CID_W | Source of the outgoing message (NODE_ID) |
| ring_out_seg | output | SEG_W | Segment of the outgoing message |
| dup_err | output | 1 | Duplicate pending signal pulse |
| save_req | input | 1 | Unload and flush the pending state |
| save_vld | output | 1 | save_data valid |
| save_data | output | STATE_W | Saved pending state |
| restore_req | input | 1 | Load the pending state |
| restore_data | input | STATE_W | State to load |

## Verification
Every result of the block is due one clock edge after the sample that causes it. Ring messages land in the pending bits at their sampling edge. A waiting core's grant appears one edge later, so it follows two edges after the last missing message. Grant, seg_active, the outgoing message, the error pulse and the save snapshot all show after the sampling edge. The bench drives and samples on the falling edge. It checks each output on the exact falling edge where it is due, and also on the one after, to confirm that pulses last one cycle. Outgoing messages are pushed into an expected queue when the core signal is driven, and a monitor pops the queue each time a message appears.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;
  localparam int unsigned DEF_CORES = 4;
  localparam int unsigned DEF_SEGS  = 4;
  localparam int unsigned DEF_NODE  = 1;

  function automatic int unsigned idw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sigbuf_table.sv
module sigbuf_table
  import sigbuf_pkg::*;
#(
  parameter int unsigned CORES   = DEF_CORES,
  parameter int unsigned SEGS    = DEF_SEGS,
  parameter int unsigned NODE_ID = DEF_NODE,
  localparam int unsigned CID_W   = idw(CORES),
  localparam int unsigned SEG_W   = idw(SEGS),
  localparam int unsigned STATE_W = CORES * SEGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [CID_W-1:0]   in_src,
  input  logic [SEG_W-1:0]   in_seg,
  input  logic [STATE_W-1:0] clr_vec,
  input  logic               save_req,
  input  logic               restore_req,
  input  logic [STATE_W-1:0] restore_data,
  output logic [STATE_W-1:0] pend,
  output logic [STATE_W-1:0] own_mask,
  output logic               dup_err,
  output logic               save_vld,
  output logic [STATE_W-1:0] save_data
);
  logic [STATE_W-1:0] set_vec, merged, pend_d, snap_d;
  logic               accept, dup_d, save_take;

  always_comb begin
    own_mask = '0;
    for (int s = 0; s < int'(SEGS); s++) own_mask[s*CORES + NODE_ID] = 1'b1;
  end

  assign accept    = in_vld && (int'(in_src) != int'(NODE_ID));
  assign set_vec   = accept ? (STATE_W'(1) << (int'(in_seg) * CORES + int'(in_src))) : '0;
  assign merged    = (pend & ~clr_vec) | set_vec;
  assign save_take = save_req && !restore_req;

  always_comb begin
    dup_d  = |(set_vec & pend & ~clr_vec);
    snap_d = save_data;
    if (restore_req) begin
      pend_d = (restore_data & ~own_mask) | set_vec;
    end else if (save_take) begin
      pend_d = '0;
      snap_d = merged;
    end else begin
      pend_d = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      dup_err   <= 1'b0;
      save_vld  <= 1'b0;
      save_data <= '0;
    end else begin
      pend      <= pend_d;
      dup_err   <= dup_d;
      save_vld  <= save_take;
      if (save_take) save_data <= snap_d;
    end
  end

  // R8
  save_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_vld |-> (pend == '0));
  // R6
  dup_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(in_vld));
  // R7
  own_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & own_mask) == '0);
endmodule

// File: rtl/sigbuf_wait_ctl.sv
module sigbuf_wait_ctl
  import sigbuf_pkg::*;
#(
  parameter int unsigned CORES   = DEF_CORES,
  parameter int unsigned SEGS    = DEF_SEGS,
  parameter int unsigned NODE_ID = DEF_NODE,
  localparam int unsigned SEG_W   = idw(SEGS),
  localparam int unsigned STATE_W = CORES * SEGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_req,
  input  logic [SEG_W-1:0]   wait_seg,
  input  logic               sig_req,
  input  logic               hold,
  input  logic [STATE_W-1:0] pend,
  input  logic [STATE_W-1:0] own_mask,
  output logic [STATE_W-1:0] clr_vec,
  output logic               wait_gnt,
  output logic               seg_active
);
  logic [CORES-1:0] row, own_row;
  logic             ready, issue, active_d;

  assign row     = pend[int'(wait_seg) * CORES +: CORES];
  assign own_row = own_mask[int'(wait_seg) * CORES +: CORES];
  assign ready   = &(row | own_row);
  assign issue   = wait_req && ready && !wait_gnt && !hold;
  assign clr_vec = issue ? (STATE_W'(~own_row) << (int'(wait_seg) * CORES)) : '0;

  always_comb begin
    active_d = seg_active;
    if (issue)        active_d = 1'b1;
    else if (sig_req) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_gnt   <= 1'b0;
      seg_active <= 1'b0;
    end else begin
      wait_gnt   <= issue;
      seg_active <= active_d;
    end
  end

  // R2
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_gnt |=> !wait_gnt);
  // R5
  gnt_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_gnt |-> seg_active);
  // R2
  gnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_gnt |-> $past(wait_req));
endmodule

// File: rtl/sigbuf_sig_out.sv
module sigbuf_sig_out
  import sigbuf_pkg::*;
#(
  parameter int unsigned CORES   = DEF_CORES,
  parameter int unsigned SEGS    = DEF_SEGS,
  parameter int unsigned NODE_ID = DEF_NODE,
  localparam int unsigned CID_W  = idw(CORES),
  localparam int unsigned SEG_W  = idw(SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_req,
  input  logic [SEG_W-1:0] sig_seg,
  output logic             out_vld,
  output logic [CID_W-1:0] out_src,
  output logic [SEG_W-1:0] out_seg
);
  logic [SEG_W-1:0] seg_d;

  assign seg_d = sig_req ? sig_seg : out_seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_src <= '0;
      out_seg <= '0;
    end else begin
      out_vld <= sig_req;
      out_src <= CID_W'(NODE_ID);
      out_seg <= seg_d;
    end
  end

  // R4
  ring_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_req |=> (out_vld && out_seg == $past(sig_seg)));
endmodule

// File: rtl/sync_sigbuf.sv
module sync_sigbuf
  import sigbuf_pkg::*;
#(
  parameter int unsigned CORES   = DEF_CORES,
  parameter int unsigned SEGS    = DEF_SEGS,
  parameter int unsigned NODE_ID = DEF_NODE,
  localparam int unsigned CID_W   = idw(CORES),
  localparam int unsigned SEG_W   = idw(SEGS),
  localparam int unsigned STATE_W = CORES * SEGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_req,
  input  logic [SEG_W-1:0]   wait_seg,
  output logic               wait_gnt,
  output logic               seg_active,
  input  logic               sig_req,
  input  logic [SEG_W-1:0]   sig_seg,
  input  logic               ring_in_vld,
  input  logic [CID_W-1:0]   ring_in_src,
  input  logic [SEG_W-1:0]   ring_in_seg,
  output logic               ring_out_vld,
  output logic [CID_W-1:0]   ring_out_src,
  output logic [SEG_W-1:0]   ring_out_seg,
  output logic               dup_err,
  input  logic               save_req,
  output logic               save_vld,
  output logic [STATE_W-1:0] save_data,
  input  logic               restore_req,
  input  logic [STATE_W-1:0] restore_data
);
  logic [STATE_W-1:0] pend, own_mask, clr_vec;
  logic               hold;

  assign hold = save_req || restore_req;

  sigbuf_table #(.CORES(CORES), .SEGS(SEGS), .NODE_ID(NODE_ID)) u_table (
    .clk(clk), .rst_n(rst_n),
    .in_vld(ring_in_vld), .in_src(ring_in_src), .in_seg(ring_in_seg),
    .clr_vec(clr_vec), .save_req(save_req), .restore_req(restore_req),
    .restore_data(restore_data), .pend(pend), .own_mask(own_mask),
    .dup_err(dup_err), .save_vld(save_vld), .save_data(save_data)
  );

  sigbuf_wait_ctl #(.CORES(CORES), .SEGS(SEGS), .NODE_ID(NODE_ID)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .wait_req(wait_req), .wait_seg(wait_seg), .sig_req(sig_req), .hold(hold),
    .pend(pend), .own_mask(own_mask), .clr_vec(clr_vec),
    .wait_gnt(wait_gnt), .seg_active(seg_active)
  );

  sigbuf_sig_out #(.CORES(CORES), .SEGS(SEGS), .NODE_ID(NODE_ID)) u_out (
    .clk(clk), .rst_n(rst_n),
    .sig_req(sig_req), .sig_seg(sig_seg),
    .out_vld(ring_out_vld), .out_src(ring_out_src), .out_seg(ring_out_seg)
  );

  // R9
  hold_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !wait_gnt);
endmodule

// File: tb/test_sync_sigbuf.sv
module test_sync_sigbuf;
  localparam int CORES = 4, SEGS = 4, NODE = 1;
  localparam int SW = CORES * SEGS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_req = 0, sig_req = 0, ring_in_vld = 0, save_req = 0, restore_req = 0;
  logic [1:0] wait_seg = 0, sig_seg = 0, ring_in_seg = 0, ring_in_src = 0;
  logic [SW-1:0] restore_data = 0;
  logic wait_gnt, seg_active, ring_out_vld, dup_err, save_vld;
  logic [1:0] ring_out_src, ring_out_seg;
  logic [SW-1:0] save_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  sync_sigbuf i_sync_sigbuf (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wait_seg(wait_seg),
    .wait_gnt(wait_gnt), .seg_active(seg_active), .sig_req(sig_req), .sig_seg(sig_seg),
    .ring_in_vld(ring_in_vld), .ring_in_src(ring_in_src), .ring_in_seg(ring_in_seg),
    .ring_out_vld(ring_out_vld), .ring_out_src(ring_out_src), .ring_out_seg(ring_out_seg),
    .dup_err(dup_err), .save_req(save_req), .save_vld(save_vld), .save_data(save_data),
    .restore_req(restore_req), .restore_data(restore_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare outgoing ring messages against the expected queue (R4)
  always @(negedge clk) begin
    if (rst_n && ring_out_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected msg", {ring_out_src, ring_out_seg}, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk({ring_out_src, ring_out_seg} == e, "R4 ring msg", {ring_out_src, ring_out_seg}, e);
      end
    end
  end

  task automatic ring_send(input int src, input int seg);
    ring_in_vld = 1; ring_in_src = 2'(src); ring_in_seg = 2'(seg);
    @(negedge clk);
    ring_in_vld = 0;
  endtask

  task automatic local_sig(input int seg);
    exp_q.push_back({2'(NODE), 2'(seg)});
    sig_req = 1; sig_seg = 2'(seg);
    @(negedge clk);
    sig_req = 0;
    chk(seg_active == 0, "R5 active falls", seg_active, 0);
    @(negedge clk);
    chk(ring_out_vld == 0, "R4 single cycle", ring_out_vld, 0);
  endtask

  task automatic do_save(input logic [SW-1:0] exp, input string req);
    save_req = 1;
    @(negedge clk);
    save_req = 0;
    chk(save_vld == 1, "R8 save_vld", save_vld, 1);
    chk(save_data == exp, req, save_data, exp);
    @(negedge clk);
    chk(save_vld == 0, "R8 save_vld pulse", save_vld, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({wait_gnt, seg_active, ring_out_vld, dup_err, save_vld} == 0, "reset state",
        {wait_gnt, seg_active, ring_out_vld, dup_err, save_vld}, 0);

    // R1, R2: wait on seg 0 while signals trickle in
    wait_req = 1; wait_seg = 0;
    ring_send(0, 0);
    chk(wait_gnt == 0, "R1 one of three", wait_gnt, 0);
    ring_send(2, 0);
    chk(wait_gnt == 0, "R1 two of three", wait_gnt, 0);
    ring_send(3, 0);
    chk(wait_gnt == 0, "R2 grant not yet", wait_gnt, 0);
    @(negedge clk);
    chk(wait_gnt == 1, "R2 grant due", wait_gnt, 1);
    chk(seg_active == 1, "R5 active with grant", seg_active, 1);
    wait_req = 0;
    @(negedge clk);
    chk(wait_gnt == 0, "R2 grant pulse", wait_gnt, 0);
    chk(seg_active == 1, "R5 active held", seg_active, 1);
    local_sig(0);
    do_save('0, "R2 bits consumed");

    // R3: early signals held
    ring_send(0, 2); ring_send(2, 2); ring_send(3, 2);
    repeat (3) @(negedge clk);
    wait_req = 1; wait_seg = 2;
    @(negedge clk);
    chk(wait_gnt == 1, "R3 early grant", wait_gnt, 1);
    wait_req = 0;
    local_sig(2);

    // R6: duplicate
    ring_send(0, 1);
    chk(dup_err == 0, "R6 first no error", dup_err, 0);
    ring_send(0, 1);
    chk(dup_err == 1, "R6 dup pulse", dup_err, 1);
    @(negedge clk);
    chk(dup_err == 0, "R6 dup single", dup_err, 0);

    // R1: seg 1 incomplete, other segment does not help
    wait_req = 1; wait_seg = 1;
    repeat (3) begin
      @(negedge clk);
      chk(wait_gnt == 0, "R1 seg1 missing", wait_gnt, 0);
    end
    wait_req = 0;

    // R7: own-source message ignored; R8 snapshot and flush
    ring_send(NODE, 3);
    do_save(16'h0010, "R7 R8 snapshot");
    do_save(16'h0000, "R8 flushed");

    // R9: restore with own bit masked, grant held off during restore
    restore_req = 1; restore_data = 16'hF000; wait_req = 1; wait_seg = 3;
    @(negedge clk);
    restore_req = 0;
    chk(wait_gnt == 0, "R9 no grant on restore", wait_gnt, 0);
    @(negedge clk);
    chk(wait_gnt == 1, "R9 restored grant", wait_gnt, 1);
    wait_req = 0;
    local_sig(3);
    do_save(16'h0000, "R9 own bit masked");

    // R9: restore beats save
    restore_req = 1; save_req = 1; restore_data = 16'h0001;
    @(negedge clk);
    restore_req = 0; save_req = 0;
    chk(save_vld == 0, "R9 save dropped", save_vld, 0);
    do_save(16'h0001, "R9 restore loaded");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all msgs seen", exp_q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule